// File: doc/BRIEF.md
# Three-Channel Timer Host Port

This block is the byte-wide programming port for three external interval counters. A 2-bit address selects one of three channel data ports or a shared control port. Control writes choose, per channel, how its 16-bit count is moved over the byte bus (low byte only, high byte only, or low then high), the counting mode and the decimal flag. Control writes also trigger snapshot commands. Data writes assemble byte pairs into a count and hand it to the counter with a one-cycle load strobe. Data reads walk through a pending status snapshot, then a frozen count, then the running count.

The counters themselves live outside. They feed their running counts and output levels in, and take the load pulses, load values and mode fields out. A read-back command can freeze the count and/or the status of any subset of channels in one write. A snapshot that is still unread is never overwritten.

Top module: `tmr_host_port`

## Requirements
- R1: A write to address 3 whose bits 7:6 name a channel (0..2) and whose bits 5:4 are nonzero sets that channel's byte access (5:4: 1 = low only, 2 = high only, 3 = low then high), its mode (bits 3:1, on `chan_mode`) and its decimal flag (bit 0, on `chan_bcd`) from the next cycle on. After reset every channel has access 3, mode 3 and flag 0.
- R2: In low-only access a data write loads `{8'h00, byte}`. In high-only access it loads `{byte, 8'h00}`. Each load raises that channel's `load_stb` bit, with the value on its `load_val` slice, for exactly the one cycle after the write.
- R3: In low-then-high access the first data byte is only held. The second byte loads `{second, first}`, and the sequence then starts over.
- R4: A control write with nonzero access restarts both the write byte order and the running-count read byte order of that channel at the low byte.
- R5: A control write with bits 5:4 = 0 freezes the channel's `cnt_live` value as seen in that write cycle.
- R6: A data read returns a pending status snapshot first and consumes it. With no status pending, it returns the frozen count. With neither, it returns the running count.
- R7: A frozen count is read in the access mode that was active when it was frozen. Low-only gives one low byte, high-only gives one high byte, and low-then-high gives the low byte and then the high byte. The freeze is released after the last byte.
- R8: A running-count read gives the low byte in low-only access and the high byte in high-only access. In low-then-high access it alternates low, high, low, and so on.
- R9: A write to address 3 with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 freezes the count, and bit 4 = 0 freezes the status byte `{out_lvl, 1'b0, access[1:0], mode[2:0], bcd}`.
- R10: A count-freeze or status-freeze request is ignored while that channel still holds an unread snapshot of the same kind.
- R11: A read of address 3 returns 0 and changes no channel's read state or snapshots.
- R12: Each channel keeps its own byte sequences, so accesses to one channel do not move another channel's sequence.
- R13: `rdata` takes the read result on the clock edge that samples `rd_en` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe (ignored when wr_en is high) |
| addr | input | 2 | 0..2 channel data, 3 control |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| cnt_live | input | 48 | Running counts, channel c at bits 16c+15:16c |
| out_lvl | input | 3 | Counter output levels, one bit per channel |
| load_stb | output | 3 | One-cycle count load pulse per channel |
| load_val | output | 48 | Count to load, channel c at bits 16c+15:16c |
| chan_mode | output | 9 | Mode per channel, channel c at bits 3c+2:3c |
| chan_bcd | output | 3 | Decimal flag per channel |

## Verification
Every result in this block appears one register stage after its stimulus. Read data is updated on the edge that samples the read strobe. A load pulse and its value appear in the cycle after the completing data write. Mode and flag outputs change on the edge of the control write. The bench drives strobes at falling edges. A scoreboard monitor samples a quarter period after each rising edge, which is the point where a read or load from the strobe just sampled must already be visible, and pops the expected item queued by the driver. Snapshot contents are fixed by the values the bench puts on `cnt_live` and `out_lvl` during the command cycle, and those values are changed before the read to show that the freeze held.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;

  localparam int NUM_CH    = 3;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = 2 * BYTE_W;
  localparam int MODE_W    = 3;
  localparam int ADDR_W    = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

  // byte access selector; ACC_NONE doubles as "no snapshot pending"
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v,
                                                   input logic hi);
    return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic out,
                                                     input acc_e acc,
                                                     input logic [MODE_W-1:0] mode,
                                                     input logic bcd);
    return {out, 1'b0, acc, mode, bcd};
  endfunction

  function automatic logic [CNT_W-1:0] form_count(input acc_e acc,
                                                   input logic [BYTE_W-1:0] b,
                                                   input logic [BYTE_W-1:0] held);
    case (acc)
      ACC_HI:   return {b, {BYTE_W{1'b0}}};
      ACC_WORD: return {b, held};
      default:  return {{BYTE_W{1'b0}}, b};
    endcase
  endfunction

endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
  import tmr_host_pkg::*;
(
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [NUM_CH-1:0]   cfg_wr,
  output logic [NUM_CH-1:0]   cnt_frz_req,
  output logic [NUM_CH-1:0]   st_frz_req,
  output logic [NUM_CH-1:0]   dat_wr
);

  logic ctrl_hit;
  logic rb_cmd;
  logic acc_zero;

  assign ctrl_hit = wr_en && (addr == CTRL_ADDR);
  assign rb_cmd   = (wdata[7:6] == 2'b11);
  assign acc_zero = (wdata[5:4] == ACC_NONE);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    logic rb_sel;
    assign sel    = !rb_cmd && (wdata[7:6] == 2'(c));
    assign rb_sel = rb_cmd && wdata[c+1];

    assign cfg_wr[c]      = ctrl_hit && sel && !acc_zero;
    assign cnt_frz_req[c] = ctrl_hit && ((sel && acc_zero) || (rb_sel && !wdata[5]));
    assign st_frz_req[c]  = ctrl_hit && rb_sel && !wdata[4];
    assign dat_wr[c]      = wr_en && (addr == ADDR_W'(c));
  end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_host_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cnt_frz_req,
  input  logic               st_frz_req,
  input  logic               dat_wr,
  input  logic               rd_hit,
  input  logic [BYTE_W-1:0]  wbyte,
  input  logic [CNT_W-1:0]   cnt_live,
  input  logic               out_lvl,
  output logic [BYTE_W-1:0]  rd_byte,
  output logic               load_stb,
  output logic [CNT_W-1:0]   load_val,
  output logic [MODE_W-1:0]  mode,
  output logic               bcd,
  output logic               cl_pend,
  output logic               st_pend
);

  acc_e               acc;
  logic               wr_hi;
  logic               rd_hi;
  logic [BYTE_W-1:0]  hold;
  acc_e               cl_state;
  logic [CNT_W-1:0]   cl_val;
  logic [BYTE_W-1:0]  st_val;

  assign cl_pend = (cl_state != ACC_NONE);

  always_comb begin
    if (st_pend)
      rd_byte = st_val;
    else if (cl_pend)
      rd_byte = pick_byte(cl_val, cl_state == ACC_HI);
    else
      rd_byte = pick_byte(cnt_live, (acc == ACC_HI) || ((acc == ACC_WORD) && rd_hi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= ACC_WORD;
      mode     <= MODE_W'(3);
      bcd      <= 1'b0;
      wr_hi    <= 1'b0;
      rd_hi    <= 1'b0;
      hold     <= '0;
      cl_state <= ACC_NONE;
      cl_val   <= '0;
      st_pend  <= 1'b0;
      st_val   <= '0;
      load_stb <= 1'b0;
      load_val <= '0;
    end else begin
      load_stb <= 1'b0;

      if (cfg_wr) begin
        acc   <= acc_e'(wbyte[5:4]);
        mode  <= wbyte[3:1];
        bcd   <= wbyte[0];
        wr_hi <= 1'b0;
        rd_hi <= 1'b0;
      end

      if (cnt_frz_req && !cl_pend) begin
        cl_val   <= cnt_live;
        cl_state <= acc;
      end

      if (st_frz_req && !st_pend) begin
        st_pend <= 1'b1;
        st_val  <= pack_status(out_lvl, acc, mode, bcd);
      end

      if (dat_wr) begin
        if ((acc == ACC_WORD) && !wr_hi) begin
          hold  <= wbyte;
          wr_hi <= 1'b1;
        end else begin
          load_stb <= 1'b1;
          load_val <= form_count(acc, wbyte, hold);
          wr_hi    <= 1'b0;
        end
      end

      if (rd_hit) begin
        if (st_pend)
          st_pend <= 1'b0;
        else if (cl_pend)
          cl_state <= (cl_state == ACC_WORD) ? ACC_HI : ACC_NONE;
        else if (acc == ACC_WORD)
          rd_hi <= !rd_hi;
      end
    end
  end

endmodule

// File: rtl/tmr_host_port.sv
module tmr_host_port
  import tmr_host_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BYTE_W-1:0]         wdata,
  output logic [BYTE_W-1:0]         rdata,
  input  logic [NUM_CH*CNT_W-1:0]   cnt_live,
  input  logic [NUM_CH-1:0]         out_lvl,
  output logic [NUM_CH-1:0]         load_stb,
  output logic [NUM_CH*CNT_W-1:0]   load_val,
  output logic [NUM_CH*MODE_W-1:0]  chan_mode,
  output logic [NUM_CH-1:0]         chan_bcd
);

  logic [NUM_CH-1:0] cfg_wr;
  logic [NUM_CH-1:0] cnt_frz_req;
  logic [NUM_CH-1:0] st_frz_req;
  logic [NUM_CH-1:0] dat_wr;
  logic [NUM_CH-1:0] rd_hit;
  logic [NUM_CH-1:0] cl_pend;
  logic [NUM_CH-1:0] st_pend;
  logic [BYTE_W-1:0] rd_byte [NUM_CH];
  logic              rd_go;
  logic [BYTE_W-1:0] rd_mux;

  assign rd_go = rd_en && !wr_en;

  tmr_ctrl_decode u_dec (
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .cfg_wr      (cfg_wr),
    .cnt_frz_req (cnt_frz_req),
    .st_frz_req  (st_frz_req),
    .dat_wr      (dat_wr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign rd_hit[c] = rd_go && (addr == ADDR_W'(c));

    tmr_chan_regs u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr      (cfg_wr[c]),
      .cnt_frz_req (cnt_frz_req[c]),
      .st_frz_req  (st_frz_req[c]),
      .dat_wr      (dat_wr[c]),
      .rd_hit      (rd_hit[c]),
      .wbyte       (wdata),
      .cnt_live    (cnt_live[c*CNT_W +: CNT_W]),
      .out_lvl     (out_lvl[c]),
      .rd_byte     (rd_byte[c]),
      .load_stb    (load_stb[c]),
      .load_val    (load_val[c*CNT_W +: CNT_W]),
      .mode        (chan_mode[c*MODE_W +: MODE_W]),
      .bcd         (chan_bcd[c]),
      .cl_pend     (cl_pend[c]),
      .st_pend     (st_pend[c])
    );
  end

  // control address reads back as zero (falls through every compare)
  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (addr == ADDR_W'(c)) rd_mux = rd_byte[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_go)
      rdata <= rd_mux;
  end

endmodule

// File: rtl/tmr_host_port_chk.sv
module tmr_host_port_chk
  import tmr_host_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         addr,
  input logic [BYTE_W-1:0]         wdata,
  input logic [BYTE_W-1:0]         rdata,
  input logic [NUM_CH-1:0]         load_stb,
  input logic [NUM_CH*MODE_W-1:0]  chan_mode,
  input logic [NUM_CH-1:0]         rd_hit,
  input logic [NUM_CH-1:0]         cl_pend,
  input logic [NUM_CH-1:0]         st_pend
);

  // R2
  load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb));

  // R2
  load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_stb) |-> $past(wr_en && (addr != CTRL_ADDR)));

  // R11
  ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && (addr == CTRL_ADDR)) |=> (rdata == '0));

  // R11
  ctrl_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && (addr == CTRL_ADDR)) |=> ($stable(st_pend) && $stable(cl_pend)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R1
    mode_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == CTRL_ADDR) && (wdata[7:6] == 2'(c)) && (wdata[5:4] != 2'b00))
      |=> (chan_mode[c*MODE_W +: MODE_W] == $past(wdata[3:1])));

    // R10
    st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_pend[c] && !rd_hit[c]) |=> st_pend[c]);

    // R6
    st_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit[c] && st_pend[c]) |=> (!st_pend[c] && $stable(cl_pend[c])));
  end

endmodule

bind tmr_host_port tmr_host_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .load_stb  (load_stb),
  .chan_mode (chan_mode),
  .rd_hit    (rd_hit),
  .cl_pend   (cl_pend),
  .st_pend   (st_pend)
);

// File: tb/tmr_host_port_tb.sv
module tmr_host_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 3;
  localparam int CW   = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [1:0]        addr = '0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic [NCH*CW-1:0] cnt_live = '0;
  logic [NCH-1:0]    out_lvl = '0;
  logic [NCH-1:0]    load_stb;
  logic [NCH*CW-1:0] load_val;
  logic [NCH*3-1:0]  chan_mode;
  logic [NCH-1:0]    chan_bcd;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0]  rd_q[$];
  string       rd_tag[$];
  int          ld_ch[$];
  logic [15:0] ld_v[$];
  string       ld_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt_live(cnt_live), .out_lvl(out_lvl),
    .load_stb(load_stb), .load_val(load_val), .chan_mode(chan_mode),
    .chan_bcd(chan_bcd)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    rd_q.push_back(e);
    rd_tag.push_back(tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic exp_load(input int ch, input logic [15:0] v, input string tag);
    ld_ch.push_back(ch);
    ld_v.push_back(v);
    ld_tag.push_back(tag);
  endtask

  task automatic set_live(input int ch, input logic [15:0] v);
    cnt_live[ch*CW +: CW] = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor: a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rst_n) begin
        if (rd_en && !wr_en) begin
          if (rd_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R13: unexpected read result actual %h expected none", rdata);
          end else begin
            chk({8'h00, rdata}, {8'h00, rd_q.pop_front()}, rd_tag.pop_front());
          end
        end
        for (int c = 0; c < NCH; c++) begin
          if (load_stb[c]) begin
            if (ld_v.size() == 0) begin
              n_chk++; n_bad++;
              $display("FAIL R2: unexpected load ch%0d actual %h expected none",
                       c, load_val[c*CW +: CW]);
            end else begin
              chk(16'(c), 16'(ld_ch.pop_front()), {ld_tag[0], " channel"});
              chk(load_val[c*CW +: CW], ld_v.pop_front(), ld_tag.pop_front());
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R1, R13)
    chk({7'd0, chan_mode}, {7'd0, 9'b011_011_011}, "R1 reset modes");
    chk({13'd0, chan_bcd}, 16'h0, "R1 reset bcd");
    chk({13'd0, load_stb}, 16'h0, "R2 reset load idle");
    chk({8'd0, rdata}, 16'h0, "R13 reset rdata");

    // R9 status read-back of ch0 right after reset
    out_lvl = 3'b101;
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'hB6, "R9 reset status ch0");

    // R1/R3 ch0 word access, mode 2
    wr(2'd3, 8'h34);
    chk({13'd0, chan_mode[2:0]}, 16'd2, "R1 ch0 mode");
    exp_load(0, 16'h3412, "R3 word load");
    wr(2'd0, 8'h12);
    wr(2'd0, 8'h34);

    // R2 ch1 low only
    wr(2'd3, 8'h50);
    exp_load(1, 16'h00AB, "R2 low-only load");
    wr(2'd1, 8'hAB);

    // R2 ch2 high only, mode 4, bcd
    wr(2'd3, 8'hA9);
    chk({13'd0, chan_mode[8:6]}, 16'd4, "R1 ch2 mode");
    chk({15'd0, chan_bcd[2]}, 16'd1, "R1 ch2 bcd");
    exp_load(2, 16'hCD00, "R2 high-only load");
    wr(2'd2, 8'hCD);

    // R12 interleaved writes
    wr(2'd0, 8'h78);
    exp_load(1, 16'h0011, "R12 ch1 between ch0 bytes");
    wr(2'd1, 8'h11);
    exp_load(0, 16'h5678, "R12 ch0 word intact");
    wr(2'd0, 8'h56);

    // R8 running count word alternation
    set_live(0, 16'hBEEF);
    rd(2'd0, 8'hEF, "R8 live low");
    set_live(0, 16'h1234);
    rd(2'd0, 8'h12, "R8 live high");

    // R5/R7/R10 count freeze on ch0
    set_live(0, 16'hA55A);
    wr(2'd3, 8'h00);
    set_live(0, 16'h1111);
    rd(2'd0, 8'h5A, "R7 frozen low");
    wr(2'd3, 8'h00);
    rd(2'd0, 8'hA5, "R10 second freeze ignored");
    set_live(0, 16'h4321);
    rd(2'd0, 8'h21, "R7 released then live low");
    rd(2'd0, 8'h43, "R8 live high after release");

    // R5/R7 ch1 low-only freeze
    set_live(1, 16'h9876);
    wr(2'd3, 8'h40);
    set_live(1, 16'h0000);
    rd(2'd1, 8'h76, "R5 frozen low-only");
    set_live(1, 16'h0055);
    rd(2'd1, 8'h55, "R7 low-only released");

    // R9/R6 read-back of count and status on ch1 and ch2
    set_live(1, 16'h2468);
    set_live(2, 16'h1357);
    out_lvl = 3'b100;
    wr(2'd3, 8'hCC);
    set_live(1, 16'h0000);
    set_live(2, 16'h0000);
    out_lvl = 3'b000;
    rd(2'd1, 8'h10, "R6 status before count ch1");
    rd(2'd1, 8'h68, "R9 frozen count ch1");
    rd(2'd2, 8'hA9, "R9 status format ch2");
    rd(2'd2, 8'h13, "R9 frozen high ch2");

    // R10 status freeze ignored while pending
    out_lvl = 3'b100;
    wr(2'd3, 8'hE8);
    out_lvl = 3'b000;
    wr(2'd3, 8'hE8);
    rd(2'd2, 8'hA9, "R10 status kept");
    set_live(2, 16'h7700);
    rd(2'd2, 8'h77, "R6 live after status");

    // R11 control address read
    set_live(0, 16'hCAFE);
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h00, "R11 control read zero");
    rd(2'd0, 8'hFE, "R11 freeze untouched low");
    rd(2'd0, 8'hCA, "R11 freeze untouched high");

    // R4 control word restarts byte order
    wr(2'd0, 8'h99);
    wr(2'd3, 8'h34);
    exp_load(0, 16'h3322, "R4 write order restarted");
    wr(2'd0, 8'h22);
    wr(2'd0, 8'h33);
    set_live(0, 16'hABCD);
    rd(2'd0, 8'hCD, "R4 live low");
    wr(2'd3, 8'h34);
    rd(2'd0, 8'hCD, "R4 read order restarted");

    // R13 rdata holds between reads
    repeat (3) @(negedge clk);
    chk({8'd0, rdata}, 16'h00CD, "R13 rdata held");

    repeat (4) @(negedge clk);
    if (rd_q.size() != 0 || ld_v.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R2: actual %0d pending items expected 0", rd_q.size() + ld_v.size());
    end
    finish_run();
  end

endmodule